// File: doc/BRIEF.md
# Card Status Change Interrupt Logic

This block watches the status lines of one card socket and turns their movements into latched change events. It samples two card-detect lines, a ready/busy line and a pair of battery-voltage-detect lines. A card-detect movement, a rising ready line, and entry into either of two battery codes each set their own sticky bit in a change register.

A configuration register selects which change sources may interrupt and which of sixteen interrupt lines carries the request. Two global inputs set the operating policy. The first picks level or pulse signalling. The second picks how software clears latched events: either every read of the change register clears it, or software writes ones back to clear individual bits.

Software reaches three registers through a select field, a read strobe and a write strobe. Read data is combinational and shows the value held before any clear that the read causes.

Top module: `csc_irq`

## Requirements
- R1: During reset and after it, the change register, the configuration register and the interrupt output are zero. Input levels present when reset is released raise no event on the first sampled cycle.
- R2: Select 0 returns the live inputs. Bit 6 is power, bit 5 is ready, bit 4 is write protect, bits 3:2 are the card-detect pair, bits 1:0 are the battery pair and bit 7 is zero. Writes to select 0 have no effect.
- R3: Change bit 3 sets on the clock edge at which the card-detect pair differs from its value at the previous edge.
- R4: Change bit 2 sets only when the ready input rises from 0 to 1. A falling ready input sets nothing.
- R5: Change bit 0 (battery dead) sets when the battery pair enters 00. Change bit 1 (battery warning) sets when the pair enters 01. Codes 10 and 11 raise no event.
- R6: Select 2 reads back the configuration written there. Bits 3:0 enable the change bits in the same positions, and bits 7:4 give the interrupt line number 0 to 15.
- R7: In level mode, output bit N is high for as long as any change bit and its enable bit are both set, where N is the configured line number. All other output bits stay zero.
- R8: In pulse mode, output bit N is high for exactly the one cycle that follows an edge at which an enabled event occurred.
- R9: With write-back mode off, a read strobe on select 1 returns the current change bits and clears all of them. Writes to select 1 are ignored.
- R10: With write-back mode on, writing to select 1 clears exactly the change bits written as ones. Reads clear nothing.
- R11: An event that arrives in the same cycle as a clear of its bit leaves that bit set.
- R12: A change source whose enable bit is zero still latches in the change register but raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cd_i | input | 2 | Card-detect pair |
| rdy_i | input | 1 | Ready/busy line, 1 = ready |
| wp_i | input | 1 | Write-protect line |
| pwr_i | input | 1 | Socket power active |
| bvd_i | input | 2 | Battery-voltage-detect pair |
| wb_clear_mode | input | 1 | 1 = clear by writing ones, 0 = clear on read |
| level_mode | input | 1 | 1 = level interrupt, 0 = pulse interrupt |
| reg_sel | input | 2 | Register select: 0 status, 1 change, 2 configuration |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for the selected register |
| irq_o | output | NIRQ | One-hot interrupt request lines |

## Verification
The two functions that can fall in the same cycle are the clearing of a change bit and the arrival of a new event for that same bit. The bench provokes this in both clear policies. In one case a read strobe on the change register lands on the edge where the card-detect pair moves. In the other case a write-back of ones lands on the edge where ready rises. Each case is judged by reading the change register on the following cycle, which must still hold the new event, and by the value the read returned in the clearing cycle itself.

// File: rtl/csc_irq.sv
module csc_irq #(
  parameter int DW   = 8,
  parameter int NIRQ = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cd_i,
  input  logic            rdy_i,
  input  logic            wp_i,
  input  logic            pwr_i,
  input  logic [1:0]      bvd_i,
  input  logic            wb_clear_mode,
  input  logic            level_mode,
  input  logic [1:0]      reg_sel,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic [NIRQ-1:0] irq_o
);
  localparam int NEV  = 4;
  localparam int IRQW = $clog2(NIRQ);
  localparam int CFGW = NEV + IRQW;
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_CHG  = 2'd1;
  localparam logic [1:0] SEL_CFG  = 2'd2;
  localparam int EV_CD   = 3;
  localparam int EV_RDY  = 2;
  localparam int EV_WARN = 1;
  localparam int EV_DEAD = 0;
  localparam logic [1:0] BV_WARN = 2'b01;
  localparam logic [1:0] BV_DEAD = 2'b00;

  logic            primed;
  logic [1:0]      cd_prev, bvd_prev;
  logic            rdy_prev;
  logic [NEV-1:0]  ev, chg_q, clr;
  logic [CFGW-1:0] cfg_q;
  logic            pulse_q;
  logic [IRQW-1:0] irq_num;
  logic            pending;

  wire rd_chg = rd_en && reg_sel == SEL_CHG;
  wire wr_chg = wr_en && reg_sel == SEL_CHG;
  wire wr_cfg = wr_en && reg_sel == SEL_CFG;

  always_comb begin
    ev = '0;
    if (primed) begin
      ev[EV_CD]   = cd_i != cd_prev;
      ev[EV_RDY]  = rdy_i && !rdy_prev;
      ev[EV_WARN] = bvd_i == BV_WARN && bvd_prev != BV_WARN;
      ev[EV_DEAD] = bvd_i == BV_DEAD && bvd_prev != BV_DEAD;
    end
  end

  always_comb begin
    clr = '0;
    if (wb_clear_mode) begin
      if (wr_chg) clr = wr_data[NEV-1:0];
    end else if (rd_chg) begin
      clr = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed   <= 1'b0;
      cd_prev  <= '0;
      rdy_prev <= 1'b0;
      bvd_prev <= '0;
      chg_q    <= '0;
      cfg_q    <= '0;
      pulse_q  <= 1'b0;
    end else begin
      primed   <= 1'b1;
      cd_prev  <= cd_i;
      rdy_prev <= rdy_i;
      bvd_prev <= bvd_i;
      chg_q    <= (chg_q & ~clr) | ev;
      pulse_q  <= |(ev & cfg_q[NEV-1:0]);
      if (wr_cfg) cfg_q <= wr_data[CFGW-1:0];
    end
  end

  assign irq_num = cfg_q[CFGW-1:NEV];
  assign pending = |(chg_q & cfg_q[NEV-1:0]);
  assign irq_o   = (level_mode ? pending : pulse_q) ? (NIRQ'(1) << irq_num) : '0;

  always_comb begin
    case (reg_sel)
      SEL_STAT: rd_data = DW'({pwr_i, rdy_i, wp_i, cd_i, bvd_i});
      SEL_CHG:  rd_data = DW'(chg_q);
      SEL_CFG:  rd_data = DW'(cfg_q);
      default:  rd_data = '0;
    endcase
  end

  assert_irq_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));

  assert_wb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_clear_mode && !wr_chg) |=> ((chg_q & $past(chg_q)) == $past(chg_q)));

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_clear_mode && rd_chg) |=> ((chg_q & ~$past(ev)) == '0));

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(cfg_q));

  assert_ready_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_q[EV_RDY]) |-> $past(rdy_i));

  assert_pulse_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && |irq_o && !(|(ev & cfg_q[NEV-1:0]))) |=> (level_mode || irq_o == '0));
endmodule

// File: tb/csc_irq_tb.sv
module csc_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cd_i = 2'b11;
  logic        rdy_i = 1'b0, wp_i = 1'b0, pwr_i = 1'b0;
  logic [1:0]  bvd_i = 2'b00;
  logic        wb_clear_mode = 1'b1, level_mode = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [15:0] irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] v;

  csc_irq dut_i (
    .clk(clk), .rst_n(rst_n), .cd_i(cd_i), .rdy_i(rdy_i), .wp_i(wp_i), .pwr_i(pwr_i),
    .bvd_i(bvd_i), .wb_clear_mode(wb_clear_mode), .level_mode(level_mode),
    .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_o(irq_o));

  always #10 clk = ~clk;

  // {cd[1:0], rdy, bvd[1:0], expected change bits[3:0]}
  localparam logic [8:0] VEC [10] = '{
    {2'b11, 1'b1, 2'b11, 4'b0100},
    {2'b11, 1'b0, 2'b11, 4'b0000},
    {2'b01, 1'b0, 2'b11, 4'b1000},
    {2'b01, 1'b0, 2'b01, 4'b0010},
    {2'b01, 1'b0, 2'b00, 4'b0001},
    {2'b00, 1'b1, 2'b10, 4'b1100},
    {2'b00, 1'b1, 2'b01, 4'b0010},
    {2'b10, 1'b0, 2'b00, 4'b1001},
    {2'b10, 1'b1, 2'b01, 4'b0110},
    {2'b10, 1'b1, 2'b01, 4'b0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] s, output logic [7:0] val);
    reg_sel = s;
    #1;
    val = rd_data;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    peek(2'd1, v); chk("R1 change in reset", v, 8'h00);
    peek(2'd2, v); chk("R1 config in reset", v, 8'h00);
    chk("R1 irq in reset", irq_o, 16'h0);
    rst_n = 1'b1;
    step(); step();
    peek(2'd1, v); chk("R1 no event on held dead code", v, 8'h00);
    bvd_i = 2'b11;
    step();
    peek(2'd1, v); chk("R5 code 11 silent", v, 8'h00);

    wr(2'd2, 8'hAF);
    for (int i = 0; i < 10; i++) begin
      {cd_i, rdy_i, bvd_i} = VEC[i][8:4];
      step();
      peek(2'd1, v);
      chk($sformatf("R3/R4/R5 row %0d change", i), v, {4'b0, VEC[i][3:0]});
      chk($sformatf("R8 row %0d pulse", i), irq_o, (VEC[i][3:0] != 0) ? 16'h0400 : 16'h0);
      step();
      chk($sformatf("R8 row %0d pulse end", i), irq_o, 16'h0);
      wr(2'd1, 8'h0F);
    end

    pwr_i = 1'b1; wp_i = 1'b1;
    peek(2'd0, v); chk("R2 live status", v, 8'h79);
    wr(2'd0, 8'h00);
    peek(2'd0, v); chk("R2 status write ignored", v, 8'h79);

    rdy_i = 1'b0; step(); rdy_i = 1'b1; step();
    peek(2'd1, v); chk("R4 ready rise", v, 8'h04);
    reg_sel = 2'd1; rd_en = 1'b1; step(); rd_en = 1'b0;
    peek(2'd1, v); chk("R10 read keeps bits", v, 8'h04);
    wr(2'd1, 8'h08);
    peek(2'd1, v); chk("R10 write clears only ones", v, 8'h04);
    rdy_i = 1'b0; step();
    rdy_i = 1'b1; wr(2'd1, 8'h04);
    peek(2'd1, v); chk("R11 event beats write-back", v, 8'h04);
    wr(2'd1, 8'h04);
    peek(2'd1, v); chk("R10 write-back clear", v, 8'h00);

    wr(2'd2, 8'h34);
    level_mode = 1'b1;
    cd_i = 2'b11; step();
    peek(2'd1, v); chk("R12 masked source latches", v, 8'h08);
    chk("R12 masked source silent", irq_o, 16'h0);
    rdy_i = 1'b0; step(); rdy_i = 1'b1; step();
    chk("R7 level asserted", irq_o, 16'h0008);
    step();
    chk("R7 level held", irq_o, 16'h0008);
    peek(2'd2, v); chk("R6 config readback", v, 8'h34);
    wr(2'd2, 8'h04);
    chk("R6 route to line 0", irq_o, 16'h0001);
    wr(2'd1, 8'h04);
    peek(2'd1, v); chk("R10 partial clear", v, 8'h08);
    chk("R7 level drops", irq_o, 16'h0);

    wb_clear_mode = 1'b0;
    wr(2'd1, 8'h0F);
    peek(2'd1, v); chk("R9 write ignored", v, 8'h08);
    rd_en = 1'b1; peek(2'd1, v); chk("R9 read value", v, 8'h08);
    step(); rd_en = 1'b0;
    peek(2'd1, v); chk("R9 read clears", v, 8'h00);

    rdy_i = 1'b0; step(); rdy_i = 1'b1; step();
    chk("R7 level on ready", irq_o, 16'h0001);
    rd_en = 1'b1; reg_sel = 2'd1; cd_i = 2'b01;
    peek(2'd1, v); chk("R11 read returns old value", v, 8'h04);
    step(); rd_en = 1'b0;
    peek(2'd1, v); chk("R11 event beats read clear", v, 8'h08);
    chk("R12 only masked bit left", irq_o, 16'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule